// File: doc/BRIEF.md
# Blocking cache miss buffer

This block tracks outstanding memory traffic for a cache that stalls on a miss. It holds a single miss slot and a single writeback slot. The cache hands it miss requests and self-generated writebacks. The block tells the cache which resource is exhausted through two separate blocked flags, and raises one bus-request line per slot.

Toward memory it offers one outgoing request at a time. The miss slot has priority over the writeback slot. A one-cycle issue pulse takes the offered request. Responses then free the slots and deliver a completion to the original requester. The cache can also query the block for a pending address and cancel a thread's miss.

Slot states and the slot commands used at the ports are:
- Miss slot command: read = 0, write = 1.
- Writeback slot command: forwarded write = 1, cache writeback = 3.
- Command driven on the bus for a line fill: 2.

Top module: `blk_miss_buf`

## Requirements
- R1: The block clears the low log2(BLK_BYTES) bits of every stored address, so `bus_addr` is always block aligned.
- R2: A write request goes to the writeback slot when any of these holds: it is uncacheable, WRITE_ALLOC is 0, or it needs no response. Such a write carries command 1. Every other request goes to the miss slot, with command 0 for a read and 1 for a write.
- R3: After reset both slots are empty and every flag is low. Filling the miss slot raises `blk_miss` and `breq_miss` on the next cycle. Filling the writeback slot raises `blk_wb` and `breq_wb` on the next cycle.
- R4: A cacheable miss is marked as a line fill, shown by `bus_fill`. While it is offered, `bus_cmd` carries the override value 2. An uncacheable miss shows its own command and keeps `bus_fill` low.
- R5: The miss slot is offered whenever it holds a request not yet issued, shown by `bus_from_wb`=0. Otherwise an unissued writeback slot is offered (`bus_from_wb`=1). With neither, `bus_valid` is 0.
- R6: On `bus_issue`, the offered slot's bus request drops. If the slot needs no response it is freed at once, with its blocked flag low on the next cycle. Otherwise it stays, marked in service.
- R7: A response (`rsp_to_wb`=0) to an in-service line-fill miss frees the miss slot. It produces no completion on the target port.
- R8: A response to any other in-service slot frees that slot. If the slot still has a waiting requester, the block raises `tgt_valid` for one cycle on the next cycle, together with the slot's original command and thread. `tgt_data` carries `rsp_data` for a read and 0 for a write.
- R9: A squash whose thread matches the miss slot removes the waiting requester. If the miss has not been issued, the squash also frees the slot and drops `breq_miss`. If the miss is in service, the slot stays until its response, which then produces no completion.
- R10: `look_miss_hit` and `look_wb_hit` are high only when the matching slot is occupied and its address equals the block base of `look_addr`.
- R11: A cache writeback taken into an empty writeback slot stores command 3 and raises `blk_wb` and `breq_wb`. It also adds one to `wb_count`. When a routed write arrives in the same cycle, the writeback wins.
- R12: A request arriving at a slot that is occupied is dropped, and so is a routed write that collides with a cache writeback. Either case sets the sticky `proto_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request from the cache |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | Request is a write |
| req_uncache | input | 1 | Request is uncacheable |
| req_need_rsp | input | 1 | Request expects a response |
| req_thread | input | TW | Requesting thread |
| cwb_valid | input | 1 | Writeback generated by the cache |
| cwb_addr | input | AW | Writeback address |
| blk_miss | output | 1 | Miss slot occupied (no miss entries) |
| blk_wb | output | 1 | Writeback slot occupied (no writeback buffers) |
| breq_miss | output | 1 | Miss slot requests the memory bus |
| breq_wb | output | 1 | Writeback slot requests the memory bus |
| bus_valid | output | 1 | An outgoing request is offered |
| bus_addr | output | AW | Offered block address (0 when idle) |
| bus_cmd | output | 2 | Offered bus command |
| bus_from_wb | output | 1 | Offered request comes from the writeback slot |
| bus_fill | output | 1 | Offered request is a line fill |
| bus_issue | input | 1 | Memory side takes the offered request |
| rsp_valid | input | 1 | Memory response |
| rsp_to_wb | input | 1 | Response belongs to the writeback slot |
| rsp_data | input | DW | Response data |
| tgt_valid | output | 1 | Completion to the original requester |
| tgt_data | output | DW | Completion data |
| tgt_cmd | output | 2 | Restored original command |
| tgt_thread | output | TW | Thread of the completed request |
| look_addr | input | AW | Lookup address |
| look_miss_hit | output | 1 | Lookup hits the miss slot |
| look_wb_hit | output | 1 | Lookup hits the writeback slot |
| squash_valid | input | 1 | Squash request |
| squash_thread | input | TW | Thread to squash |
| wb_count | output | CW | Count of accepted cache writebacks |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The properties assume three things about the environment:
- `bus_issue` is pulsed only while `bus_valid` is high.
- A response arrives only for a slot that is in service.
- A squash never shares a cycle with an issue.

The bench's random phase derives these pulses from its own model of the slot states, so it stays within these rules. Requests to occupied slots are still sent on purpose, because they are defined behaviour (R12).

// File: rtl/blk_miss_buf.sv
module blk_miss_buf #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 2,
  parameter int CW = 16,
  parameter int BLK_BYTES = 64,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_uncache,
  input  logic          req_need_rsp,
  input  logic [TW-1:0] req_thread,
  input  logic          cwb_valid,
  input  logic [AW-1:0] cwb_addr,
  output logic          blk_miss,
  output logic          blk_wb,
  output logic          breq_miss,
  output logic          breq_wb,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_cmd,
  output logic          bus_from_wb,
  output logic          bus_fill,
  input  logic          bus_issue,
  input  logic          rsp_valid,
  input  logic          rsp_to_wb,
  input  logic [DW-1:0] rsp_data,
  output logic          tgt_valid,
  output logic [DW-1:0] tgt_data,
  output logic [1:0]    tgt_cmd,
  output logic [TW-1:0] tgt_thread,
  input  logic [AW-1:0] look_addr,
  output logic          look_miss_hit,
  output logic          look_wb_hit,
  input  logic          squash_valid,
  input  logic [TW-1:0] squash_thread,
  output logic [CW-1:0] wb_count,
  output logic          proto_err
);
  localparam int OFS = $clog2(BLK_BYTES);
  localparam logic [1:0] C_WRITE = 2'd1, C_FILL = 2'd2, C_WBACK = 2'd3;

  function automatic logic [AW-1:0] blk_base(input logic [AW-1:0] a);
    return {a[AW-1:OFS], {OFS{1'b0}}};
  endfunction

  logic          m_v, m_s, m_nr, m_f, m_tg;
  logic [AW-1:0] m_a;
  logic [1:0]    m_c;
  logic [TW-1:0] m_t;
  logic          w_v, w_s, w_nr, w_tg;
  logic [AW-1:0] w_a;
  logic [1:0]    w_c;
  logic [TW-1:0] w_t;

  logic to_wb, take_miss, take_wbr, take_cwb, bad;
  logic off_m, off_w, iss_m, iss_w, rsp_m, rsp_w, sq_hit;

  assign to_wb     = req_write & (req_uncache | ~WRITE_ALLOC | ~req_need_rsp);
  assign take_miss = req_valid & ~to_wb & ~m_v;
  assign take_cwb  = cwb_valid & ~w_v;
  assign take_wbr  = req_valid & to_wb & ~w_v & ~cwb_valid;
  assign bad       = (req_valid & (to_wb ? (w_v | cwb_valid) : m_v)) | (cwb_valid & w_v);

  assign off_m  = m_v & ~m_s;
  assign off_w  = ~off_m & w_v & ~w_s;
  assign iss_m  = bus_issue & off_m;
  assign iss_w  = bus_issue & off_w;
  assign rsp_m  = rsp_valid & ~rsp_to_wb & m_v & m_s;
  assign rsp_w  = rsp_valid & rsp_to_wb & w_v & w_s;
  assign sq_hit = squash_valid & m_v & (m_t == squash_thread);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_v <= 1'b0; m_s <= 1'b0; m_nr <= 1'b0; m_f <= 1'b0; m_tg <= 1'b0;
      m_a <= '0; m_c <= '0; m_t <= '0;
    end else if (take_miss) begin
      m_v  <= 1'b1;
      m_s  <= 1'b0;
      m_a  <= blk_base(req_addr);
      m_c  <= {1'b0, req_write};
      m_nr <= req_need_rsp;
      m_tg <= req_need_rsp;
      m_f  <= ~req_uncache;
      m_t  <= req_thread;
    end else if (rsp_m) begin
      m_v <= 1'b0;
    end else if (sq_hit) begin
      m_tg <= 1'b0;
      if (!m_s) m_v <= 1'b0;
    end else if (iss_m) begin
      if (m_nr) m_s <= 1'b1;
      else      m_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_v <= 1'b0; w_s <= 1'b0; w_nr <= 1'b0; w_tg <= 1'b0;
      w_a <= '0; w_c <= '0; w_t <= '0;
    end else if (take_cwb) begin
      w_v  <= 1'b1;
      w_s  <= 1'b0;
      w_a  <= blk_base(cwb_addr);
      w_c  <= C_WBACK;
      w_nr <= 1'b0;
      w_tg <= 1'b0;
      w_t  <= '0;
    end else if (take_wbr) begin
      w_v  <= 1'b1;
      w_s  <= 1'b0;
      w_a  <= blk_base(req_addr);
      w_c  <= C_WRITE;
      w_nr <= req_need_rsp;
      w_tg <= req_need_rsp;
      w_t  <= req_thread;
    end else if (rsp_w) begin
      w_v <= 1'b0;
    end else if (iss_w) begin
      if (w_nr) w_s <= 1'b1;
      else      w_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_valid <= 1'b0; tgt_data <= '0; tgt_cmd <= '0; tgt_thread <= '0;
      wb_count <= '0; proto_err <= 1'b0;
    end else begin
      tgt_valid <= (rsp_m & ~m_f & m_tg) | (rsp_w & w_tg);
      if (rsp_m) begin
        tgt_data   <= (m_c == 2'd0) ? rsp_data : '0;
        tgt_cmd    <= m_c;
        tgt_thread <= m_t;
      end else if (rsp_w) begin
        tgt_data   <= '0;
        tgt_cmd    <= w_c;
        tgt_thread <= w_t;
      end
      if (take_cwb) wb_count <= wb_count + 1'b1;
      if (bad) proto_err <= 1'b1;
    end
  end

  assign blk_miss    = m_v;
  assign blk_wb      = w_v;
  assign breq_miss   = m_v & ~m_s;
  assign breq_wb     = w_v & ~w_s;
  assign bus_valid   = off_m | off_w;
  assign bus_from_wb = off_w;
  assign bus_fill    = off_m & m_f;
  assign bus_addr    = off_m ? m_a : (off_w ? w_a : '0);
  assign bus_cmd     = off_m ? (m_f ? C_FILL : m_c) : (off_w ? w_c : 2'd0);

  assign look_miss_hit = m_v & (m_a == blk_base(look_addr));
  assign look_wb_hit   = w_v & (w_a == blk_base(look_addr));
endmodule

// File: rtl/blk_miss_buf_chk.sv
module blk_miss_buf_chk #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BLK_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          cwb_valid,
  input logic          blk_miss,
  input logic          blk_wb,
  input logic          breq_miss,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_from_wb,
  input logic          bus_issue,
  input logic          squash_valid,
  input logic          look_miss_hit,
  input logic          look_wb_hit,
  input logic [CW-1:0] wb_count,
  input logic          proto_err
);
  localparam int OFS = $clog2(BLK_BYTES);

  AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_addr[OFS-1:0] == '0); // R1
  AST_MISS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !blk_miss |=> blk_miss && breq_miss); // R3
  AST_MISS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    breq_miss |-> bus_valid && !bus_from_wb); // R5
  AST_ISSUE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_issue && bus_valid && !bus_from_wb && !squash_valid |=> !breq_miss); // R6
  AST_LOOK_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    look_miss_hit |-> blk_miss); // R10
  AST_LOOK_WB: assert property (@(posedge clk) disable iff (!rst_n)
    look_wb_hit |-> blk_wb); // R10
  AST_WB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cwb_valid && !blk_wb |=> wb_count == $past(wb_count) + 1'b1); // R11
  AST_ERR_WB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cwb_valid && blk_wb |=> proto_err); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R12
endmodule

bind blk_miss_buf blk_miss_buf_chk #(.AW(AW), .CW(CW), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .cwb_valid(cwb_valid), .blk_miss(blk_miss), .blk_wb(blk_wb), .breq_miss(breq_miss),
  .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_from_wb(bus_from_wb),
  .bus_issue(bus_issue), .squash_valid(squash_valid), .look_miss_hit(look_miss_hit),
  .look_wb_hit(look_wb_hit), .wb_count(wb_count), .proto_err(proto_err)
);

// File: tb/blk_miss_buf_bench.sv
module blk_miss_buf_bench;
  localparam int PERIOD = 10;
  localparam int AW = 32, DW = 32, TW = 2, CW = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_uncache = 0, req_need_rsp = 0;
  logic [AW-1:0] req_addr = 0, cwb_addr = 0, look_addr = 0;
  logic [TW-1:0] req_thread = 0, squash_thread = 0;
  logic cwb_valid = 0, bus_issue = 0, rsp_valid = 0, rsp_to_wb = 0, squash_valid = 0;
  logic [DW-1:0] rsp_data = 0;
  logic blk_miss, blk_wb, breq_miss, breq_wb, bus_valid, bus_from_wb, bus_fill;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_cmd, tgt_cmd;
  logic tgt_valid, look_miss_hit, look_wb_hit, proto_err;
  logic [DW-1:0] tgt_data;
  logic [TW-1:0] tgt_thread;
  logic [CW-1:0] wb_count;

  always #(PERIOD/2) clk = ~clk;

  blk_miss_buf u_blk_miss_buf (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic cmp(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: index 0 = miss slot, 1 = writeback slot
  bit mv[2], ms[2], mnr[2], mf[2], mtg[2];
  logic [AW-1:0] ma[2];
  int mc[2], mt[2];
  int wbcnt = 0;
  bit merr = 0, etv = 0;
  longint etd = 0;
  int etc_ = 0, ett = 0;
  bit towb, offm, offw;

  function automatic logic [AW-1:0] base(input logic [AW-1:0] a);
    return a & ~32'h3f;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin mv[i] = 0; ms[i] = 0; mtg[i] = 0; end
      wbcnt = 0; merr = 0; etv = 0;
    end else begin
      towb = req_write && (req_uncache || !req_need_rsp);
      offm = mv[0] && !ms[0];
      offw = !offm && mv[1] && !ms[1];
      etv = 0;
      if (req_valid && (towb ? (mv[1] || cwb_valid) : mv[0])) merr = 1;
      if (cwb_valid && mv[1]) merr = 1;
      if (req_valid && !towb && !mv[0]) begin
        mv[0] = 1; ms[0] = 0; ma[0] = base(req_addr); mc[0] = req_write;
        mnr[0] = req_need_rsp; mtg[0] = req_need_rsp; mf[0] = !req_uncache; mt[0] = req_thread;
      end else if (rsp_valid && !rsp_to_wb && mv[0] && ms[0]) begin
        mv[0] = 0;
        if (!mf[0] && mtg[0]) begin etv = 1; etd = (mc[0] == 0) ? rsp_data : 0; etc_ = mc[0]; ett = mt[0]; end
      end else if (squash_valid && mv[0] && mt[0] == squash_thread) begin
        mtg[0] = 0;
        if (!ms[0]) mv[0] = 0;
      end else if (bus_issue && offm) begin
        if (mnr[0]) ms[0] = 1; else mv[0] = 0;
      end
      if (cwb_valid && !mv[1]) begin
        mv[1] = 1; ms[1] = 0; ma[1] = base(cwb_addr); mc[1] = 3; mnr[1] = 0; mtg[1] = 0; mt[1] = 0;
        wbcnt = (wbcnt + 1) % 65536;
      end else if (req_valid && towb && !mv[1]) begin
        mv[1] = 1; ms[1] = 0; ma[1] = base(req_addr); mc[1] = 1;
        mnr[1] = req_need_rsp; mtg[1] = req_need_rsp; mt[1] = req_thread;
      end else if (rsp_valid && rsp_to_wb && mv[1] && ms[1]) begin
        mv[1] = 0;
        if (mtg[1]) begin etv = 1; etd = 0; etc_ = mc[1]; ett = mt[1]; end
      end else if (bus_issue && offw) begin
        if (mnr[1]) ms[1] = 1; else mv[1] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit om, ow;
      om = mv[0] && !ms[0];
      ow = !om && mv[1] && !ms[1];
      cmp("R3 blk_miss", blk_miss, mv[0]);
      cmp("R3 blk_wb", blk_wb, mv[1]);
      cmp("R6 breq_miss", breq_miss, om);
      cmp("R6 breq_wb", breq_wb, mv[1] && !ms[1]);
      cmp("R5 bus_valid", bus_valid, om || ow);
      cmp("R5 bus_from_wb", bus_from_wb, ow);
      if (om || ow) begin
        cmp("R1 bus_addr", bus_addr, om ? ma[0] : ma[1]);
        cmp("R4 bus_cmd", bus_cmd, om ? (mf[0] ? 2 : mc[0]) : mc[1]);
        cmp("R4 bus_fill", bus_fill, om && mf[0]);
      end
      cmp("R8 tgt_valid", tgt_valid, etv);
      if (etv) begin
        cmp("R8 tgt_data", tgt_data, etd);
        cmp("R8 tgt_cmd", tgt_cmd, etc_);
        cmp("R8 tgt_thread", tgt_thread, ett);
      end
      cmp("R10 look_miss_hit", look_miss_hit, mv[0] && ma[0] == base(look_addr));
      cmp("R10 look_wb_hit", look_wb_hit, mv[1] && ma[1] == base(look_addr));
      cmp("R11 wb_count", wb_count, wbcnt);
      cmp("R12 proto_err", proto_err, merr);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    req_valid = 0; cwb_valid = 0; bus_issue = 0; rsp_valid = 0; squash_valid = 0;
  endtask

  task automatic miss(input logic [AW-1:0] a, input bit wr, input bit unc, input bit nr, input int th);
    req_valid = 1; req_addr = a; req_write = wr; req_uncache = unc; req_need_rsp = nr; req_thread = th[TW-1:0];
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    cmp("R3 reset blk_miss", blk_miss, 0);
    cmp("R3 reset bus_valid", bus_valid, 0);
    cmp("R12 reset proto_err", proto_err, 0);
    @(posedge clk); #1;
    // cacheable read -> line fill
    miss(32'h1234_5678, 0, 0, 1, 1); look_addr = 32'h1234_5600; step();
    @(negedge clk); cmp("R4 fill cmd", bus_cmd, 2); cmp("R1 aligned", bus_addr, 32'h1234_5640);
    @(posedge clk); #1;
    bus_issue = 1; step();
    rsp_valid = 1; rsp_data = 32'h1111; step();
    @(negedge clk); cmp("R7 fill frees miss", blk_miss, 0); cmp("R7 no completion", tgt_valid, 0);
    @(posedge clk); #1;
    // uncacheable read with response
    miss(32'h0000_0104, 0, 1, 1, 2); step();
    bus_issue = 1; step();
    rsp_valid = 1; rsp_data = 32'hCAFE; step();
    @(negedge clk); cmp("R8 read data", tgt_data, 32'hCAFE); cmp("R8 thread", tgt_thread, 2);
    @(posedge clk); #1;
    // uncacheable write -> wb slot
    miss(32'h0000_2004, 1, 1, 1, 3); step();
    @(negedge clk); cmp("R2 routed to wb", bus_from_wb, 1); cmp("R2 miss slot empty", blk_miss, 0);
    @(posedge clk); #1;
    bus_issue = 1; step();
    rsp_valid = 1; rsp_to_wb = 1; step();
    rsp_to_wb = 0;
    // posted write freed at issue
    miss(32'h0000_3000, 1, 0, 0, 0); step();
    bus_issue = 1; step();
    @(negedge clk); cmp("R6 freed at issue", blk_wb, 0);
    @(posedge clk); #1;
    // writeback and miss together, miss wins
    cwb_valid = 1; cwb_addr = 32'h0000_4010; miss(32'h0000_5000, 0, 0, 1, 0); step();
    @(negedge clk); cmp("R5 miss first", bus_from_wb, 0); cmp("R11 count", wb_count, 1);
    @(posedge clk); #1;
    bus_issue = 1; step();
    @(negedge clk); cmp("R5 wb next", bus_from_wb, 1);
    @(posedge clk); #1;
    look_addr = 32'h0000_5020; step();
    bus_issue = 1; step();
    // blocked request while miss in service
    miss(32'h0000_6000, 0, 0, 1, 1); step();
    @(negedge clk); cmp("R12 blocked error", proto_err, 1); cmp("R12 slot kept", look_miss_hit, 1);
    @(posedge clk); #1;
    rsp_valid = 1; step();
    // squash unissued miss
    miss(32'h0000_7000, 0, 1, 1, 3); step();
    squash_valid = 1; squash_thread = 3; step();
    @(negedge clk); cmp("R9 squash frees", blk_miss, 0); cmp("R9 breq dropped", breq_miss, 0);
    @(posedge clk); #1;
    // squash in-service miss
    miss(32'h0000_8000, 0, 1, 1, 2); step();
    bus_issue = 1; step();
    squash_valid = 1; squash_thread = 2; step();
    @(negedge clk); cmp("R9 in service kept", blk_miss, 1);
    @(posedge clk); #1;
    rsp_valid = 1; step();
    @(negedge clk); cmp("R9 no completion", tgt_valid, 0);
    @(posedge clk); #1;
    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit om, ow;
      om = mv[0] && !ms[0];
      ow = !om && mv[1] && !ms[1];
      req_valid = ($urandom % 4) == 0;
      req_addr = $urandom; req_write = $urandom; req_uncache = $urandom;
      req_need_rsp = $urandom; req_thread = $urandom;
      cwb_valid = ($urandom % 6) == 0; cwb_addr = $urandom;
      look_addr = ($urandom % 2) ? ma[$urandom % 2] + ($urandom % 64) : $urandom;
      bus_issue = (om || ow) && ($urandom % 3) == 0;
      if ((mv[0] && ms[0]) || (mv[1] && ms[1])) begin
        rsp_valid = ($urandom % 3) == 0;
        rsp_to_wb = (mv[0] && ms[0]) ? ((mv[1] && ms[1]) ? $urandom : 0) : 1;
        rsp_data = $urandom;
      end
      squash_valid = !bus_issue && ($urandom % 8) == 0;
      squash_thread = $urandom;
      step();
    end
    @(negedge clk);
    finish_up();
  end
endmodule